// File: doc/BRIEF.md
# Power Mode Entry Controller

This block sequences a small system between its running state and four low-power modes, numbered PM0 (lightest) through PM3 (deepest). Software chooses a target by writing a two-bit selection field. It then writes a trigger bit in a separate control register. The controller moves to the chosen mode and drives the clock-gating enables for the CPU and the peripherals. Any interrupt request brings the system back to the running state.

Two guards protect the deeper modes PM1 to PM3. First, the high-speed oscillator must report stable and the low-power oscillator must report its calibration done. Second, after a wake from a deep mode, a programmable number of running cycles must pass before the next deep entry. A trigger that meets a guard is kept waiting and is not lost. On every entry, hardware clears the selection field back to 00.

Register access is a plain single-cycle write strobe with a combinational read path. There is no data stream, so the block has no valid/ready handshake and never stalls a write.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the state is as follows. `power_mode` is 4 (running). The selection field is 00. `cpu_clk_en` and `periph_clk_en` are both 1, and `trig_pending` is 0.
- R2: A write with `reg_sel`=1 stores `reg_wdata[1:0]` as the selection field and ignores bits 7:2. A read with `rd_sel`=1 returns the field in bits 1:0, with zeros in bits 7:2.
- R3: A read with `rd_sel`=0 (the control register) always returns 8'h00. Writing 1 to control bit 0 is a trigger, and it acts only while `power_mode` is 4.
- R4: Suppose a trigger is written while the field is 00 and no interrupt is present. Then `power_mode` reads 0 (PM0) in the cycle after the write.
- R5: From the cycle after any mode entry, the selection field reads 00.
- R6: Entry into a field value of 1, 2 or 3 needs `hs_osc_stable`=1 and `lp_cal_done`=1 in the same cycle. Otherwise the trigger is held, with `trig_pending`=1 and the target captured at the write. It is entered at the first clock where every guard holds.
- R7: Waking from PM1 to PM3 clears a running-cycle counter. The counter advances once per running cycle, and deep entry is refused until it reaches `min_active_cycles`. At reset the counter starts saturated.
- R8: An `irq_req` seen while in any power mode makes `power_mode` read 4 in the next cycle.
- R9: An `irq_req` in the same cycle as a trigger write wins. The block stays running and nothing is left pending. An `irq_req` while a trigger is pending cancels it.
- R10: Writing 1 to control bit 1 forces `cpu_clk_en` to 0 until reset. This holds across power modes and does not change mode sequencing.
- R11: `power_mode` codes are 0 to 3 for PM0 to PM3 and 4 for running. `periph_clk_en` is 1 only in running and PM0. `cpu_clk_en` is 1 only in running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 mode selection |
| reg_wdata | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 mode selection |
| reg_rdata | output | 8 | Combinational read data |
| irq_req | input | 1 | Interrupt request, wakes or cancels |
| hs_osc_stable | input | 1 | High-speed oscillator stable flag |
| lp_cal_done | input | 1 | Low-power oscillator calibration done flag |
| min_active_cycles | input | 16 | Minimum running cycles between deep entries |
| power_mode | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| trig_pending | output | 1 | A trigger is waiting on a guard |

## Verification
The hardest situation to reach from the ports is a trigger that is held back by the running-cycle counter after a wake from a deep mode. The stimulus first enters PM3 with both oscillator flags set and `min_active_cycles` at 20. It wakes with an interrupt and then writes a new trigger at once. The bench then checks that entry lands exactly on the cycle the counter reaches the limit. A behavioural reference model, stepped every clock, also compares every output throughout: through the cancel-while-pending case, the interrupt-versus-trigger collision, and the sticky CPU halt.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int MODE_W = 2;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PM_0   = 3'd0,
    PM_1   = 3'd1,
    PM_2   = 3'd2,
    PM_3   = 3'd3,
    PM_ACT = 3'd4
  } pmode_e;

  function automatic logic is_deep(input pmode_e m);
    return (m == PM_1) || (m == PM_2) || (m == PM_3);
  endfunction
endpackage

// File: rtl/pm_regfile.sv
module pm_regfile
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rdata,
  input  logic              enter,
  output logic [MODE_W-1:0] mode_field,
  output logic              trig_wr,
  output logic              halt
);
  localparam int PAD_W = DATA_W - MODE_W;

  logic wr_ctrl, wr_mode;

  assign wr_ctrl = wr_en && !wr_sel;
  assign wr_mode = wr_en && wr_sel;
  assign trig_wr = wr_ctrl && wdata[0];

  // Selection field: an entry clears it, otherwise software may load it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_field <= '0;
    else if (enter)   mode_field <= '0;
    else if (wr_mode) mode_field <= wdata[MODE_W-1:0];
  end

  // Reserved control bit: once set it stays set until reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    halt <= 1'b0;
    else if (wr_ctrl && wdata[1])  halt <= 1'b1;
  end

  always_comb begin
    rdata = '0;
    if (rd_sel) rdata = {{PAD_W{1'b0}}, mode_field};
  end

  assert_field_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> mode_field == '0);
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
endmodule

// File: rtl/pm_active_timer.sv
module pm_active_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             wake_deep,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '1;
    else if (wake_deep)              cnt_q <= '0;
    else if (active && cnt_q < limit) cnt_q <= cnt_q + 1'b1;
  end

  assign done = cnt_q >= limit;

  assert_restart_on_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_deep |=> cnt_q == '0);
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= limit) && $stable(limit) |=> cnt_q >= limit || $past(wake_deep));
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_wr,
  input  logic [MODE_W-1:0] mode_field,
  input  logic              irq,
  input  logic              hs_stable,
  input  logic              lp_cal,
  input  logic              timer_done,
  output logic              enter,
  output logic              wake_deep,
  output pmode_e            pm,
  output logic              pending
);
  pmode_e            pm_q;
  logic              pend_q;
  logic [MODE_W-1:0] ptgt_q;
  logic [MODE_W-1:0] tgt;
  logic              active, want, deep_ok, ok, wake;

  assign active    = (pm_q == PM_ACT);
  assign tgt       = trig_wr ? mode_field : ptgt_q;
  assign want      = active && !irq && (trig_wr || pend_q);
  assign deep_ok   = hs_stable && lp_cal && timer_done;
  assign ok        = (tgt == '0) || deep_ok;
  assign enter     = want && ok;
  assign wake      = !active && irq;
  assign wake_deep = wake && is_deep(pm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pm_q <= PM_ACT;
    else if (enter) pm_q <= pmode_e'({1'b0, tgt});
    else if (wake)  pm_q <= PM_ACT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ptgt_q <= '0;
    end else if (active && irq) begin
      pend_q <= 1'b0;
    end else if (enter) begin
      pend_q <= 1'b0;
    end else if (active && trig_wr) begin
      pend_q <= 1'b1;
      ptgt_q <= mode_field;
    end
  end

  assign pm      = pm_q;
  assign pending = pend_q;

  assert_deep_needs_osc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active && !(hs_stable && lp_cal) |=> !is_deep(pm_q));
  assert_deep_needs_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active && !timer_done |=> !is_deep(pm_q));
  assert_irq_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active && irq |=> pm_q == PM_ACT);
  assert_irq_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active && irq |=> pm_q == PM_ACT && !pend_q);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_req,
  input  logic              hs_osc_stable,
  input  logic              lp_cal_done,
  input  logic [CNT_W-1:0]  min_active_cycles,
  output logic [CODE_W-1:0] power_mode,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              trig_pending
);
  logic [MODE_W-1:0] mode_field;
  logic              trig_wr, halt, enter, wake_deep, timer_done;
  pmode_e            pm;

  pm_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel),
    .wdata(reg_wdata), .rd_sel(rd_sel), .rdata(reg_rdata),
    .enter(enter), .mode_field(mode_field), .trig_wr(trig_wr), .halt(halt)
  );

  pm_active_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(pm == PM_ACT), .wake_deep(wake_deep),
    .limit(min_active_cycles), .done(timer_done)
  );

  pm_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .mode_field(mode_field),
    .irq(irq_req), .hs_stable(hs_osc_stable), .lp_cal(lp_cal_done),
    .timer_done(timer_done), .enter(enter), .wake_deep(wake_deep),
    .pm(pm), .pending(trig_pending)
  );

  assign power_mode    = pm;
  assign cpu_clk_en    = (pm == PM_ACT) && !halt;
  assign periph_clk_en = (pm == PM_ACT) || (pm == PM_0);

  assert_halt_gates_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !cpu_clk_en);
  assert_sleep_gates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_deep(pm) |-> !periph_clk_en && !cpu_clk_en);
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       reg_wr = 0, reg_sel = 0, rd_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       irq_req = 0, hs_osc_stable = 0, lp_cal_done = 0;
  logic [15:0] min_active_cycles = 0;
  logic [2:0] power_mode;
  logic       cpu_clk_en, periph_clk_en, trig_pending;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl u0 (.*);

  // Behavioural reference model
  int m_pm = 4, m_field = 0, m_pend = 0, m_ptgt = 0, m_halt = 0, m_cnt = 65535;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pm = 4; m_field = 0; m_pend = 0; m_ptgt = 0; m_halt = 0; m_cnt = 65535;
    end else begin
      int n_pm, n_field, n_pend, n_ptgt, n_halt, n_cnt, tgt;
      bit trig, wrc, wrm, want, ok, ent;
      n_pm = m_pm; n_field = m_field; n_pend = m_pend; n_ptgt = m_ptgt;
      n_halt = m_halt; n_cnt = m_cnt; ent = 0;
      wrc  = reg_wr && !reg_sel;
      wrm  = reg_wr && reg_sel;
      trig = wrc && reg_wdata[0];
      if (m_pm == 4) begin
        if (irq_req) n_pend = 0;
        else begin
          tgt  = trig ? m_field : m_ptgt;
          want = trig || (m_pend != 0);
          ok   = (tgt == 0) || (hs_osc_stable && lp_cal_done && m_cnt >= int'(min_active_cycles));
          if (want && ok) begin n_pm = tgt; n_pend = 0; ent = 1; end
          else if (trig) begin n_pend = 1; n_ptgt = m_field; end
        end
        if (m_cnt < int'(min_active_cycles)) n_cnt = m_cnt + 1;
      end else if (irq_req) begin
        if (m_pm != 0) n_cnt = 0;
        n_pm = 4;
      end
      if (ent) n_field = 0;
      else if (wrm) n_field = reg_wdata[1:0];
      if (wrc && reg_wdata[1]) n_halt = 1;
      m_pm = n_pm; m_field = n_field; m_pend = n_pend; m_ptgt = n_ptgt;
      m_halt = n_halt; m_cnt = n_cnt;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " power_mode"}, power_mode, m_pm);
      chk({cur_req, " cpu_clk_en"}, cpu_clk_en, (m_pm == 4) && !m_halt);
      chk({cur_req, " periph_clk_en"}, periph_clk_en, (m_pm == 4) || (m_pm == 0));
      chk({cur_req, " trig_pending"}, trig_pending, m_pend);
      chk({cur_req, " reg_rdata"}, reg_rdata, rd_sel ? m_field : 0);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(bit sel, logic [7:0] d, bit irq = 0);
    reg_wr = 1; reg_sel = sel; reg_wdata = d; irq_req = irq;
    cyc();
    reg_wr = 0; reg_wdata = 0; irq_req = 0;
  endtask

  task automatic pulse_irq();
    irq_req = 1; cyc(); irq_req = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 mode", power_mode, 4);
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 periph", periph_clk_en, 1);
    chk("R1 pend", trig_pending, 0);
    rd_sel = 1; #1 chk("R1 field", reg_rdata, 0);

    cur_req = "R2";
    wr(1, 8'hFD);
    chk("R2 field read", reg_rdata, 1);
    cur_req = "R3";
    rd_sel = 0; #1 chk("R3 ctrl read", reg_rdata, 0);
    rd_sel = 1;

    cur_req = "R4";
    wr(1, 8'h00);
    wr(0, 8'h01);
    chk("R4 enter PM0", power_mode, 0);
    chk("R11 PM0 periph", periph_clk_en, 1);
    chk("R11 PM0 cpu", cpu_clk_en, 0);
    cur_req = "R8";
    cyc(3);
    pulse_irq();
    chk("R8 wake", power_mode, 4);

    cur_req = "R6";
    wr(1, 8'h03);
    wr(0, 8'h01);
    cyc(4);
    chk("R6 held", trig_pending, 1);
    chk("R6 still running", power_mode, 4);
    hs_osc_stable = 1; cyc(2);
    chk("R6 needs cal", power_mode, 4);
    lp_cal_done = 1; cyc();
    chk("R6 enter PM3", power_mode, 3);
    cur_req = "R5";
    chk("R5 field cleared", reg_rdata, 0);
    chk("R11 PM3 periph", periph_clk_en, 0);

    cur_req = "R7";
    min_active_cycles = 16'd20;
    pulse_irq();
    wr(1, 8'h02);
    wr(0, 8'h01);
    cyc(10);
    chk("R7 waiting", power_mode, 4);
    chk("R7 pending", trig_pending, 1);
    cyc(12);
    chk("R7 entered PM2", power_mode, 2);
    cyc(2);
    pulse_irq();

    cur_req = "R9";
    min_active_cycles = 16'd0;
    wr(1, 8'h01);
    wr(0, 8'h01, 1);
    chk("R9 irq wins", power_mode, 4);
    chk("R9 nothing pending", trig_pending, 0);
    hs_osc_stable = 0;
    wr(0, 8'h01);
    chk("R9 pending set", trig_pending, 1);
    pulse_irq();
    chk("R9 cancelled", trig_pending, 0);
    hs_osc_stable = 1; cyc(3);
    chk("R9 no late entry", power_mode, 4);

    cur_req = "R10";
    wr(0, 8'h02);
    chk("R10 cpu halted", cpu_clk_en, 0);
    chk("R10 still running", power_mode, 4);
    wr(1, 8'h02);
    wr(0, 8'h03);
    chk("R10 entry still works", power_mode, 2);
    pulse_irq();
    chk("R10 halt kept", cpu_clk_en, 0);
    cyc(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule